// File: doc/BRIEF.md
# Shared Dual-Port Byte Memory with Doorbell Interrupts

This block is a 1024-byte memory that two agents reach through two independent ports. One port faces a host bus with ISA-style memory cycles: active-low read and write strobes, plus an address that is claimed only when its upper bits match an 8-bit base value set on configuration switches. The other port faces a peripheral controller. It has its own active-low select and its own read and write strobes. Both ports can read and write the array in the same cycle. The only interaction between them happens when both touch the same byte.

The two highest addresses of the array act as doorbells. A write from the far side to a side's mailbox byte pulls that side's active-low interrupt pin low. The byte written is stored like any other byte, so it carries a message code. The interrupt is released when the owning side reads its own mailbox byte. A typical use is for the host to place a request in the array and write the peripheral's mailbox. The peripheral sees one pin fall, serves the request, and can answer the same way.

Both ports are synchronous to one clock. Writes take effect on the rising edge at which the strobes are sampled. Read data, interrupt changes and the busy flag appear after that same edge.

Top module: `dpmem_doorbell`

## Requirements
- R1: Both ports address the same 1024-byte array. A byte written through one port is returned by a later read of that address through either port. Read data appears on the port's data output after the edge that samples the read strobe, and holds its value when no read is made.
- R2: The host port acts only when `host_addr[17:10]` equals `win_base`, and the array index is `host_addr[9:0]`. Outside the window a host write changes no byte and a host read leaves `host_rdata` unchanged. A new `win_base` moves the window.
- R3: A host read is `host_memr_n` low and a host write is `host_memw_n` low. A peripheral access needs `pr_cs_n` low, with `pr_rd_n` low to read and `pr_wr_n` low to write.
- R4: Writes from both ports to different addresses in the same cycle both land, and `pr_busy` stays low.
- R5: When both ports write the same address in the same cycle, the host byte is stored and the peripheral byte is dropped. `pr_busy` is high for exactly the cycle after that edge and low otherwise.
- R6: When one port writes an address that the other port reads in the same cycle, the reading port receives the byte stored before the write.
- R7: A peripheral write to 0x3FE drives `host_irq_n` low after that edge. A host write to 0x3FF drives `pr_irq_n` low after that edge.
- R8: A host read of 0x3FE releases `host_irq_n` (high) after that edge, and a peripheral read of 0x3FF releases `pr_irq_n`. When a set and a release of the same interrupt meet on one edge, the interrupt stays asserted.
- R9: A side's own write to its own mailbox (host to 0x3FE, peripheral to 0x3FF) stores the byte but leaves that side's interrupt unchanged. A peripheral mailbox write dropped under R5 raises nothing.
- R10: Mailbox bytes 0x3FE and 0x3FF store and return written data like ordinary bytes.
- R11: During and after reset, both interrupt outputs are high, `pr_busy` is low, and both read-data outputs are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_base | input | 8 | Switch setting compared with the upper host address bits |
| host_addr | input | 18 | Host address: window bits [17:10], array index [9:0] |
| host_wdata | input | 8 | Host write data |
| host_memr_n | input | 1 | Host read strobe, active low |
| host_memw_n | input | 1 | Host write strobe, active low |
| host_rdata | output | 8 | Host read data, registered |
| host_irq_n | output | 1 | Host doorbell interrupt, active low |
| pr_addr | input | 10 | Peripheral array index |
| pr_wdata | input | 8 | Peripheral write data |
| pr_cs_n | input | 1 | Peripheral select, active low |
| pr_rd_n | input | 1 | Peripheral read strobe, active low |
| pr_wr_n | input | 1 | Peripheral write strobe, active low |
| pr_rdata | output | 8 | Peripheral read data, registered |
| pr_busy | output | 1 | High for one cycle after a peripheral write lost to the host |
| pr_irq_n | output | 1 | Peripheral doorbell interrupt, active low |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it: read data, the busy flag, and the set or release of an interrupt. A stored byte is visible to any read sampled on a later edge. The bench changes inputs 1 ns after a rising edge, holds them through the next edge, and samples 1 ns after that edge, so each check reads the value produced by exactly the edge that consumed its stimulus. Checks where timing matters, such as the busy pulse ending, an interrupt holding through a combined set and release, and a read seeing the byte from before a write, are each followed by a further idle or read cycle to confirm the next state.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    // Pending doorbell state, one flag per side.
    typedef struct packed {
        logic host_pend;
        logic pr_pend;
    } mbox_t;

endpackage

// File: rtl/dpm_win_dec.sv
module dpm_win_dec #(
    parameter int BASE_W = 8
) (
    input  logic [BASE_W-1:0] addr_hi,
    input  logic [BASE_W-1:0] base,
    output logic              hit
);

    always_comb begin
        hit = (addr_hi == base);
    end

endmodule

// File: rtl/dpm_arbiter.sv
module dpm_arbiter #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we_req,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              p_we_req,
    input  logic [ADDR_W-1:0] p_addr,
    output logic              h_we,
    output logic              p_we,
    output logic              p_busy
);

    logic clash;
    logic busy_d, busy_q;

    always_comb begin
        clash  = h_we_req && p_we_req && (h_addr == p_addr);
        h_we   = h_we_req;
        p_we   = p_we_req && !clash;
        busy_d = clash;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_d;
    end

    assign p_busy = busy_q;

    // R5: a busy pulse only ever follows a same-address double write
    p_busy_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        p_busy |-> ($past(h_we_req) && $past(p_we_req) && $past(h_addr == p_addr)));

    // R5: a double write to one address always flags the peripheral
    p_busy_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we_req && p_we_req && h_addr == p_addr) |=> p_busy);

    // R4: distinct-address writes never block the peripheral
    p_no_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (p_we_req && !(h_we_req && h_addr == p_addr)) |-> p_we);

endmodule

// File: rtl/dpm_store.sv
module dpm_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic              h_re,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              p_we,
    input  logic              p_re,
    input  logic [ADDR_W-1:0] p_addr,
    input  logic [DATA_W-1:0] p_wdata,
    output logic [DATA_W-1:0] p_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] h;
        logic [DATA_W-1:0] p;
    } rd_t;

    logic [DATA_W-1:0] mem [DEPTH];
    rd_t rd_d, rd_q;

    // Registered reads sample the array before this edge's writes land.
    always_comb begin
        rd_d = rd_q;
        if (h_re) rd_d.h = mem[h_addr];
        if (p_re) rd_d.p = mem[p_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    // Peripheral first, host last: the host byte survives a shared address.
    always_ff @(posedge clk) begin
        if (p_we) mem[p_addr] <= p_wdata;
        if (h_we) mem[h_addr] <= h_wdata;
    end

    assign h_rdata = rd_q.h;
    assign p_rdata = rd_q.p;

    // R1: with no read strobe the output register holds
    p_hold_h_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !h_re |=> $stable(h_rdata));
    p_hold_p_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !p_re |=> $stable(p_rdata));

endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox
    import dpm_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_we,
    input  logic              h_re,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              p_we,
    input  logic              p_re,
    input  logic [ADDR_W-1:0] p_addr,
    output logic              h_irq_n,
    output logic              p_irq_n
);

    localparam logic [ADDR_W-1:0] BOX_P = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BOX_H = BOX_P - 1'b1;

    mbox_t st_d, st_q;
    logic  ring_h, ring_p, ack_h, ack_p;

    always_comb begin
        ring_h = p_we && (p_addr == BOX_H);
        ring_p = h_we && (h_addr == BOX_P);
        ack_h  = h_re && (h_addr == BOX_H);
        ack_p  = p_re && (p_addr == BOX_P);
        st_d   = st_q;
        if (ack_h)  st_d.host_pend = 1'b0;
        if (ring_h) st_d.host_pend = 1'b1;
        if (ack_p)  st_d.pr_pend   = 1'b0;
        if (ring_p) st_d.pr_pend   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign h_irq_n = !st_q.host_pend;
    assign p_irq_n = !st_q.pr_pend;

    // R7: far-side writes ring the doorbell
    p_ring_host_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (p_we && p_addr == BOX_H) |=> !h_irq_n);
    p_ring_pr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (h_we && h_addr == BOX_P) |=> !p_irq_n);

    // R8: an own read without a concurrent ring releases the line
    p_ack_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (h_re && h_addr == BOX_H && !(p_we && p_addr == BOX_H)) |=> h_irq_n);
    p_ack_pr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (p_re && p_addr == BOX_P && !(h_we && h_addr == BOX_P)) |=> p_irq_n);

    // R9: without ring or read on its box, a line does not move
    p_quiet_host_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(p_we && p_addr == BOX_H) && !(h_re && h_addr == BOX_H)) |=> $stable(h_irq_n));

endmodule

// File: rtl/dpmem_doorbell.sv
module dpmem_doorbell #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int BASE_W = 8,
    localparam int HADDR_W = ADDR_W + BASE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BASE_W-1:0]  win_base,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic               host_memr_n,
    input  logic               host_memw_n,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_irq_n,
    input  logic [ADDR_W-1:0]  pr_addr,
    input  logic [DATA_W-1:0]  pr_wdata,
    input  logic               pr_cs_n,
    input  logic               pr_rd_n,
    input  logic               pr_wr_n,
    output logic [DATA_W-1:0]  pr_rdata,
    output logic               pr_busy,
    output logic               pr_irq_n
);

    logic              hit;
    logic              h_we_req, h_re, p_we_req, p_re;
    logic              h_we, p_we;
    logic [ADDR_W-1:0] h_idx;

    dpm_win_dec #(.BASE_W(BASE_W)) u_win (
        .addr_hi (host_addr[HADDR_W-1:ADDR_W]),
        .base    (win_base),
        .hit     (hit)
    );

    always_comb begin
        h_idx    = host_addr[ADDR_W-1:0];
        h_we_req = hit && !host_memw_n;
        h_re     = hit && !host_memr_n;
        p_we_req = !pr_cs_n && !pr_wr_n;
        p_re     = !pr_cs_n && !pr_rd_n;
    end

    dpm_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .h_we_req (h_we_req),
        .h_addr   (h_idx),
        .p_we_req (p_we_req),
        .p_addr   (pr_addr),
        .h_we     (h_we),
        .p_we     (p_we),
        .p_busy   (pr_busy)
    );

    dpm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_we    (h_we),
        .h_re    (h_re),
        .h_addr  (h_idx),
        .h_wdata (host_wdata),
        .h_rdata (host_rdata),
        .p_we    (p_we),
        .p_re    (p_re),
        .p_addr  (pr_addr),
        .p_wdata (pr_wdata),
        .p_rdata (pr_rdata)
    );

    dpm_mailbox #(.ADDR_W(ADDR_W)) u_box (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_we    (h_we),
        .h_re    (h_re),
        .h_addr  (h_idx),
        .p_we    (p_we),
        .p_re    (p_re),
        .p_addr  (pr_addr),
        .h_irq_n (host_irq_n),
        .p_irq_n (pr_irq_n)
    );

    // R2: host strobes outside the window leave the read register alone
    p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr[HADDR_W-1:ADDR_W] != win_base) |=> $stable(host_rdata));

endmodule

// File: tb/test_dpmem_doorbell.sv
module test_dpmem_doorbell;

    localparam logic [7:0] BASE = 8'hD4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  win_base = BASE;
    logic [17:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_memr_n = 1'b1, host_memw_n = 1'b1;
    logic [7:0]  host_rdata;
    logic        host_irq_n;
    logic [9:0]  pr_addr = '0;
    logic [7:0]  pr_wdata = '0;
    logic        pr_cs_n = 1'b1, pr_rd_n = 1'b1, pr_wr_n = 1'b1;
    logic [7:0]  pr_rdata;
    logic        pr_busy, pr_irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dpmem_doorbell i_dpmem_doorbell (
        .clk(clk), .rst_n(rst_n), .win_base(win_base),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_memr_n(host_memr_n), .host_memw_n(host_memw_n),
        .host_rdata(host_rdata), .host_irq_n(host_irq_n),
        .pr_addr(pr_addr), .pr_wdata(pr_wdata), .pr_cs_n(pr_cs_n),
        .pr_rd_n(pr_rd_n), .pr_wr_n(pr_wr_n), .pr_rdata(pr_rdata),
        .pr_busy(pr_busy), .pr_irq_n(pr_irq_n)
    );

    // {host_port, write, addr[9:0], wdata[7:0], expected_read[7:0]}
    localparam int NV = 8;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 1'b1, 10'h010, 8'h11, 8'h00},
        {1'b0, 1'b1, 10'h020, 8'h22, 8'h00},
        {1'b0, 1'b0, 10'h010, 8'h00, 8'h11},
        {1'b1, 1'b0, 10'h020, 8'h00, 8'h22},
        {1'b1, 1'b1, 10'h3FD, 8'hC3, 8'h00},
        {1'b0, 1'b0, 10'h3FD, 8'h00, 8'hC3},
        {1'b0, 1'b1, 10'h000, 8'h5A, 8'h00},
        {1'b1, 1'b0, 10'h000, 8'h00, 8'h5A}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        host_memr_n = 1'b1; host_memw_n = 1'b1;
        pr_cs_n = 1'b1; pr_rd_n = 1'b1; pr_wr_n = 1'b1;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic h_drive(input bit wr, input logic [9:0] a, input logic [7:0] d);
        host_addr = {win_base, a};
        host_wdata = d;
        if (wr) host_memw_n = 1'b0; else host_memr_n = 1'b0;
    endtask

    task automatic p_drive(input bit wr, input logic [9:0] a, input logic [7:0] d);
        pr_addr = a; pr_wdata = d; pr_cs_n = 1'b0;
        if (wr) pr_wr_n = 1'b0; else pr_rd_n = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11 host_irq_n", {7'd0, host_irq_n}, 8'h01);
        chk("R11 pr_irq_n",   {7'd0, pr_irq_n},   8'h01);
        chk("R11 pr_busy",    {7'd0, pr_busy},    8'h00);
        chk("R11 host_rdata", host_rdata, 8'h00);
        chk("R11 pr_rdata",   pr_rdata,   8'h00);
        rst_n = 1'b1;
        step();

        // R1 R3 table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][27]) h_drive(VEC[i][26], VEC[i][25:16], VEC[i][15:8]);
            else            p_drive(VEC[i][26], VEC[i][25:16], VEC[i][15:8]);
            step();
            idle();
            if (!VEC[i][26])
                chk(VEC[i][27] ? "R1 R3 table host read" : "R1 R3 table pr read",
                    VEC[i][27] ? host_rdata : pr_rdata, VEC[i][7:0]);
        end

        // R2 write outside window changes nothing
        host_addr = {BASE ^ 8'h01, 10'h010}; host_wdata = 8'hEE; host_memw_n = 1'b0;
        step(); idle();
        h_drive(0, 10'h010, 8'h00); step(); idle();
        chk("R2 miss write dropped", host_rdata, 8'h11);
        // R2 read outside window holds rdata
        host_addr = {BASE ^ 8'h80, 10'h020}; host_memr_n = 1'b0;
        step(); idle();
        chk("R2 miss read holds", host_rdata, 8'h11);
        // R2 moved window
        win_base = 8'h3C;
        h_drive(1, 10'h030, 8'h99); step(); idle();
        p_drive(0, 10'h030, 8'h00); step(); idle();
        chk("R2 moved window", pr_rdata, 8'h99);
        win_base = BASE;

        // R4 simultaneous distinct writes
        h_drive(1, 10'h101, 8'h31); p_drive(1, 10'h202, 8'h42); step(); idle();
        chk("R4 busy low", {7'd0, pr_busy}, 8'h00);
        h_drive(0, 10'h202, 8'h00); p_drive(0, 10'h101, 8'h00); step(); idle();
        chk("R4 host sees pr byte", host_rdata, 8'h42);
        chk("R4 pr sees host byte", pr_rdata, 8'h31);

        // R5 same-address collision
        h_drive(1, 10'h055, 8'h77); p_drive(1, 10'h055, 8'h88); step(); idle();
        chk("R5 busy pulse", {7'd0, pr_busy}, 8'h01);
        step();
        chk("R5 busy ends", {7'd0, pr_busy}, 8'h00);
        p_drive(0, 10'h055, 8'h00); step(); idle();
        chk("R5 host byte kept", pr_rdata, 8'h77);

        // R6 read-during-write returns old byte
        h_drive(1, 10'h066, 8'h10); step(); idle();
        p_drive(1, 10'h066, 8'h20); h_drive(0, 10'h066, 8'h00); step(); idle();
        chk("R6 old byte", host_rdata, 8'h10);
        h_drive(0, 10'h066, 8'h00); step(); idle();
        chk("R6 new byte later", host_rdata, 8'h20);

        // R7 R8 R10 doorbells
        p_drive(1, 10'h3FE, 8'hA5); step(); idle();
        chk("R7 host irq set", {7'd0, host_irq_n}, 8'h00);
        chk("R7 pr irq untouched", {7'd0, pr_irq_n}, 8'h01);
        h_drive(0, 10'h3FE, 8'h00); step(); idle();
        chk("R10 host box code", host_rdata, 8'hA5);
        chk("R8 host irq cleared", {7'd0, host_irq_n}, 8'h01);
        h_drive(1, 10'h3FF, 8'h5C); step(); idle();
        chk("R7 pr irq set", {7'd0, pr_irq_n}, 8'h00);
        p_drive(0, 10'h3FF, 8'h00); step(); idle();
        chk("R10 pr box code", pr_rdata, 8'h5C);
        chk("R8 pr irq cleared", {7'd0, pr_irq_n}, 8'h01);

        // R9 own-side writes
        h_drive(1, 10'h3FE, 8'h01); step(); idle();
        chk("R9 host own write", {7'd0, host_irq_n}, 8'h01);
        p_drive(1, 10'h3FF, 8'h02); step(); idle();
        chk("R9 pr own write", {7'd0, pr_irq_n}, 8'h01);
        p_drive(0, 10'h3FF, 8'h00); step(); idle();
        chk("R10 R9 own write stored", pr_rdata, 8'h02);

        // R8 set and clear on one edge
        p_drive(1, 10'h3FE, 8'h61); step(); idle();
        h_drive(0, 10'h3FE, 8'h00); p_drive(1, 10'h3FE, 8'h62); step(); idle();
        chk("R8 set wins", {7'd0, host_irq_n}, 8'h00);
        chk("R6 box old byte", host_rdata, 8'h61);
        h_drive(0, 10'h3FE, 8'h00); step(); idle();
        chk("R8 later clear", {7'd0, host_irq_n}, 8'h01);
        chk("R10 box new byte", host_rdata, 8'h62);

        // R5 R9 collision on host mailbox: dropped write rings nothing
        h_drive(1, 10'h3FE, 8'h70); p_drive(1, 10'h3FE, 8'h71); step(); idle();
        chk("R5 box busy", {7'd0, pr_busy}, 8'h01);
        chk("R9 dropped ring", {7'd0, host_irq_n}, 8'h01);
        h_drive(0, 10'h3FE, 8'h00); step(); idle();
        chk("R5 box host byte", host_rdata, 8'h70);

        finish_run();
    end

endmodule